// File: doc/BRIEF.md
# Asynchronous SRAM access controller

This block sits between an internal clocked bus and an external 16-bit static RAM that has no clock of its own. It takes one word request at a time through a valid/ready handshake. Each request carries an address, a write flag, write data and a two-bit lane mask. The controller turns the request into the select, write, output-enable and lane-enable strobe sequence that the memory expects. It drives the address and write data from registers and controls a tri-state enable for the shared data bus. On a read it samples the bus and returns the word with a one-cycle done pulse.

Every strobe phase is a whole number of clock cycles. Each length comes from a nanosecond minimum of the memory and the clock period, rounded up. The memory takes time to release the shared bus after its output enable rises. For that reason a write that follows a read always waits a fixed release gap with every strobe inactive, and the controller never drives the bus while the memory may still be driving it. Between accesses both chip selects are inactive, so the memory drops into its automatic standby.

Top module: `sram_ctl`

## Requirements
- R1: After reset and whenever no access is in progress, the outputs sit at their idle values: mem_ce1_n=1, mem_ce2=0, mem_we_n=1, mem_oe_n=1, mem_be_n=2'b11, mem_dq_oe=0 and req_ready=1.
- R2: A request is taken on the clock edge where req_valid and req_ready are both high. req_ready is low from the next cycle until the access ends. A request held valid during that time is not taken early.
- R3: A read puts the latched address on mem_addr and drives mem_ce1_n=0, mem_ce2=1, mem_oe_n=0 and mem_we_n=1, starting the cycle after acceptance. These strobes last RD_CYC cycles, where RD_CYC is the largest of ceil(T_AA/period), ceil(T_OE/period) and ceil(T_RC/period). With the defaults RD_CYC is 6.
- R4: A read samples mem_din at the clock edge that ends its strobes. In the following cycle rsp_done is high for exactly one cycle and rsp_rdata holds the sampled lanes. Mask bit 0 selects bits 7:0 and drives mem_be_n[0] low. Mask bit 1 selects bits 15:8 and drives mem_be_n[1] low. A lane whose mask bit is 0 reads as zero.
- R5: A write asserts the chip selects and drives mem_we_n=0, mem_oe_n=1, mem_dq_oe=1, the address and mem_dout for WR_CYC cycles. WR_CYC is the largest of ceil(T_WP/period), ceil(T_AW/period), ceil(T_DW/period) and ceil(T_RC/period)-1; with the defaults it is 5. Then comes one hold cycle with mem_we_n=1 while the selects, lane enables, address and data stay unchanged. After that everything is released.
- R6: A write changes only the memory lanes whose mask bit is 1. A write with mask 2'b00 changes nothing.
- R7: A write accepted after a read first spends HZ_CYC = ceil(T_HZ/period) cycles with all strobes inactive (2 with the defaults). mem_dq_oe is never high while mem_oe_n is low, and it never rises within T_HZ of a rising edge of mem_oe_n.
- R8: rsp_done never pulses for a write.
- R9: mem_addr does not change while a chip select stays asserted. Two successive address changes are at least T_RC apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Lane mask, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| rsp_done | output | 1 | One-cycle pulse when read data is valid |
| rsp_rdata | output | 16 | Read data, disabled lanes zero |
| mem_addr | output | 19 | Memory address |
| mem_ce1_n | output | 1 | Active-low chip select |
| mem_ce2 | output | 1 | Active-high chip select |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_be_n | output | 2 | Active-low lane enables, bit 0 lower, bit 1 upper |
| mem_dout | output | 16 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Tri-state enable for mem_dout |
| mem_din | input | 16 | Data returned by the memory |

## Verification
Full-word writes and reads at the lowest, a middle and the highest address show whether the address, the strobe lengths and the data paths are right. Single-lane writes and reads in each lane, and a write with an empty mask, separate correct lane steering from writes that touch the wrong byte or reads that leak a disabled lane. Writes that follow a read are compared with writes that follow a write, which shows whether the release gap appears exactly when it should. Requests held valid while the controller is busy, followed by a long random mix with idle gaps of varying length, check that nothing is taken early and that the timing holds in every ordering. A memory model in the bench returns data only after the access time has elapsed, and it reports bus contention and early re-driving after a read.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_RD    = 3'd1,
    ST_TURN  = 3'd2,
    ST_WR    = 3'd3,
    ST_WHOLD = 3'd4
  } ctl_state_e;

  // Whole clock cycles covering a nanosecond minimum, never below one.
  function automatic int unsigned ns_to_cycles(input int unsigned ns,
                                               input int unsigned period_ns);
    int unsigned c;
    c = (ns + period_ns - 1) / period_ns;
    if (c == 0) c = 1;
    return c;
  endfunction

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_ctl_timer.sv
module sram_ctl_timer #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign expired = (cnt == '0);

endmodule

// File: rtl/sram_ctl_lanes.sv
module sram_ctl_lanes #(
  parameter  int LANES  = 2,
  parameter  int LANE_W = 8,
  localparam int DW     = LANES * LANE_W
) (
  input  logic [LANES-1:0] mask,
  input  logic [DW-1:0]    rd_raw,
  output logic [LANES-1:0] be_n,
  output logic [DW-1:0]    rd_kept
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign be_n[g] = ~mask[g];
    assign rd_kept[g*LANE_W +: LANE_W] = mask[g] ? rd_raw[g*LANE_W +: LANE_W] : '0;
  end

endmodule

// File: rtl/sram_ctl.sv
module sram_ctl
  import sram_ctl_pkg::*;
#(
  parameter  int ADDR_W        = 19,
  parameter  int LANES         = 2,
  parameter  int LANE_W        = 8,
  parameter  int CLK_PERIOD_NS = 10,
  parameter  int T_RC_NS       = 55,
  parameter  int T_AA_NS       = 55,
  parameter  int T_OE_NS       = 25,
  parameter  int T_WP_NS       = 40,
  parameter  int T_AW_NS       = 45,
  parameter  int T_DW_NS       = 25,
  parameter  int T_HZ_NS       = 20,
  localparam int DATA_W        = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [LANES-1:0]  req_mask,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce1_n,
  output logic              mem_ce2,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [LANES-1:0]  mem_be_n,
  output logic [DATA_W-1:0] mem_dout,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_din
);

  localparam int unsigned RC_C   = ns_to_cycles(T_RC_NS, CLK_PERIOD_NS);
  localparam int unsigned RD_CYC = max_u(max_u(ns_to_cycles(T_AA_NS, CLK_PERIOD_NS),
                                               ns_to_cycles(T_OE_NS, CLK_PERIOD_NS)), RC_C);
  localparam int unsigned WR_CYC = max_u(max_u(ns_to_cycles(T_WP_NS, CLK_PERIOD_NS),
                                               ns_to_cycles(T_AW_NS, CLK_PERIOD_NS)),
                                         max_u(ns_to_cycles(T_DW_NS, CLK_PERIOD_NS), RC_C - 1));
  localparam int unsigned HZ_CYC = ns_to_cycles(T_HZ_NS, CLK_PERIOD_NS);
  localparam int unsigned CNT_MAX = max_u(max_u(RD_CYC, WR_CYC), HZ_CYC);
  localparam int CNT_W = $clog2(CNT_MAX + 1);

  ctl_state_e state;
  logic               accept;
  logic               last_rd;
  logic [LANES-1:0]   mask_q;
  logic [LANES-1:0]   lane_mask;
  logic [LANES-1:0]   be_n_nxt;
  logic [DATA_W-1:0]  rd_kept;
  logic               tmr_load;
  logic [CNT_W-1:0]   tmr_val;
  logic               tmr_expired;

  assign accept    = req_valid && req_ready;
  assign lane_mask = (state == ST_IDLE) ? req_mask : mask_q;

  sram_ctl_lanes #(
    .LANES  (LANES),
    .LANE_W (LANE_W)
  ) u_lanes (
    .mask    (lane_mask),
    .rd_raw  (mem_din),
    .be_n    (be_n_nxt),
    .rd_kept (rd_kept)
  );

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    if (state == ST_IDLE && accept) begin
      tmr_load = 1'b1;
      if (!req_write)   tmr_val = CNT_W'(RD_CYC - 1);
      else if (last_rd) tmr_val = CNT_W'(HZ_CYC - 1);
      else              tmr_val = CNT_W'(WR_CYC - 1);
    end else if (state == ST_TURN && tmr_expired) begin
      tmr_load = 1'b1;
      tmr_val  = CNT_W'(WR_CYC - 1);
    end
  end

  sram_ctl_timer #(
    .CNT_W (CNT_W)
  ) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      req_ready <= 1'b1;
      rsp_done  <= 1'b0;
      rsp_rdata <= '0;
      mem_addr  <= '0;
      mem_ce1_n <= 1'b1;
      mem_ce2   <= 1'b0;
      mem_we_n  <= 1'b1;
      mem_oe_n  <= 1'b1;
      mem_be_n  <= '1;
      mem_dout  <= '0;
      mem_dq_oe <= 1'b0;
      mask_q    <= '0;
      last_rd   <= 1'b0;
    end else begin
      rsp_done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            req_ready <= 1'b0;
            mem_addr  <= req_addr;
            mem_dout  <= req_wdata;
            mask_q    <= req_mask;
            if (!req_write) begin
              mem_ce1_n <= 1'b0;
              mem_ce2   <= 1'b1;
              mem_oe_n  <= 1'b0;
              mem_be_n  <= be_n_nxt;
              state     <= ST_RD;
            end else if (last_rd) begin
              state <= ST_TURN;
            end else begin
              mem_ce1_n <= 1'b0;
              mem_ce2   <= 1'b1;
              mem_we_n  <= 1'b0;
              mem_be_n  <= be_n_nxt;
              mem_dq_oe <= 1'b1;
              state     <= ST_WR;
            end
          end
        end
        ST_RD: begin
          if (tmr_expired) begin
            rsp_rdata <= rd_kept;
            rsp_done  <= 1'b1;
            mem_ce1_n <= 1'b1;
            mem_ce2   <= 1'b0;
            mem_oe_n  <= 1'b1;
            mem_be_n  <= '1;
            last_rd   <= 1'b1;
            req_ready <= 1'b1;
            state     <= ST_IDLE;
          end
        end
        ST_TURN: begin
          if (tmr_expired) begin
            mem_ce1_n <= 1'b0;
            mem_ce2   <= 1'b1;
            mem_we_n  <= 1'b0;
            mem_be_n  <= be_n_nxt;
            mem_dq_oe <= 1'b1;
            last_rd   <= 1'b0;
            state     <= ST_WR;
          end
        end
        ST_WR: begin
          if (tmr_expired) begin
            mem_we_n <= 1'b1;
            state    <= ST_WHOLD;
          end
        end
        ST_WHOLD: begin
          mem_ce1_n <= 1'b1;
          mem_ce2   <= 1'b0;
          mem_be_n  <= '1;
          mem_dq_oe <= 1'b0;
          req_ready <= 1'b1;
          state     <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_IDLE_STANDBY: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |-> (mem_ce1_n && !mem_ce2 && mem_we_n && mem_oe_n && !mem_dq_oe)); // R1
  AST_BUSY_AFTER_TAKE: assert property (@(posedge clk) disable iff (rst)
    accept |=> !req_ready); // R2
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    rsp_done |=> !rsp_done); // R4
  AST_WRITE_STROBES: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> (mem_dq_oe && mem_oe_n && !mem_ce1_n && mem_ce2)); // R5
  AST_NO_DRIVE_INTO_READ: assert property (@(posedge clk) disable iff (rst)
    mem_dq_oe |-> mem_oe_n); // R7
  AST_RELEASE_GAP: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_oe_n) |=> !mem_dq_oe); // R7
  AST_DONE_ONLY_READ: assert property (@(posedge clk) disable iff (rst)
    rsp_done |-> $past(!mem_oe_n)); // R8
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
    (!mem_ce1_n && $past(!mem_ce1_n)) |-> $stable(mem_addr)); // R9

endmodule

// File: tb/sram_ctl_test.sv
module sram_ctl_test;

  localparam int P_NS  = 10;
  localparam int T_AA  = 55;
  localparam int T_OE  = 25;
  localparam int T_RC  = 55;
  localparam int T_WP  = 40;
  localparam int T_AW  = 45;
  localparam int T_DW  = 25;
  localparam int T_HZ  = 20;

  function automatic int cdiv(input int ns);
    return (ns + P_NS - 1) / P_NS;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int RD_B = mx(mx(cdiv(T_AA), cdiv(T_OE)), cdiv(T_RC));
  localparam int WR_B = mx(mx(cdiv(T_WP), cdiv(T_AW)), mx(cdiv(T_DW), cdiv(T_RC) - 1));
  localparam int HZ_B = cdiv(T_HZ);

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [18:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_mask = '0;
  logic        rsp_done;
  logic [15:0] rsp_rdata;
  logic [18:0] mem_addr;
  logic        mem_ce1_n, mem_ce2, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [1:0]  mem_be_n;
  logic [15:0] mem_dout;
  logic [15:0] mem_din = 16'h5A5A;

  always #5 clk = ~clk;

  sram_ctl uut (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_ce1_n(mem_ce1_n), .mem_ce2(mem_ce2),
    .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_be_n(mem_be_n),
    .mem_dout(mem_dout), .mem_dq_oe(mem_dq_oe), .mem_din(mem_din)
  );

  int vectors = 0;
  int miscompares = 0;
  bit chk_en = 1'b0;

  typedef struct {
    bit rdy; bit ce; bit we; bit oe;
    logic [1:0] be_n; bit dq;
    logic [18:0] addr; logic [15:0] dout;
    bit done; logic [15:0] rdata;
    int tag;
  } exp_t;

  exp_t exp_q[$];
  logic [15:0] mirror [int];
  logic [15:0] sram_mem [int];
  bit last_rd_b = 1'b0;

  function automatic string tag_name(input int t);
    case (t)
      2: return "R3,R2";
      3: return "R4";
      4: return "R5";
      5: return "R5,R8";
      6: return "R7,R2";
      default: return "R1";
    endcase
  endfunction

  function automatic exp_t idle_e();
    exp_t e;
    e.rdy = 1; e.ce = 0; e.we = 0; e.oe = 0; e.be_n = 2'b11; e.dq = 0;
    e.addr = '0; e.dout = '0; e.done = 0; e.rdata = '0; e.tag = 1;
    return e;
  endfunction

  function automatic logic [15:0] keep_lanes(input logic [15:0] v, input logic [1:0] m);
    return {m[1] ? v[15:8] : 8'h00, m[0] ? v[7:0] : 8'h00};
  endfunction

  function automatic void push_req(input bit w, input logic [18:0] a,
                                   input logic [15:0] d, input logic [1:0] m);
    exp_t e;
    logic [15:0] old;
    old = mirror.exists(int'(a)) ? mirror[int'(a)] : 16'h0000;
    if (!w) begin
      for (int i = 0; i < RD_B; i++) begin
        e = idle_e(); e.rdy = 0; e.ce = 1; e.oe = 1; e.be_n = ~m; e.addr = a; e.tag = 2;
        exp_q.push_back(e);
      end
      e = idle_e(); e.done = 1; e.rdata = keep_lanes(old, m); e.tag = 3;
      exp_q.push_back(e);
      last_rd_b = 1'b1;
    end else begin
      if (last_rd_b) begin
        for (int i = 0; i < HZ_B; i++) begin
          e = idle_e(); e.rdy = 0; e.tag = 6;
          exp_q.push_back(e);
        end
      end
      for (int i = 0; i < WR_B; i++) begin
        e = idle_e(); e.rdy = 0; e.ce = 1; e.we = 1; e.be_n = ~m; e.dq = 1;
        e.addr = a; e.dout = d; e.tag = 4;
        exp_q.push_back(e);
      end
      e = idle_e(); e.rdy = 0; e.ce = 1; e.be_n = ~m; e.dq = 1; e.addr = a; e.dout = d; e.tag = 5;
      exp_q.push_back(e);
      mirror[int'(a)] = {m[1] ? d[15:8] : old[15:8], m[0] ? d[7:0] : old[7:0]};
      last_rd_b = 1'b0;
    end
  endfunction

  // Acceptance monitor
  always @(posedge clk) begin
    if (!rst && req_valid && req_ready) push_req(req_write, req_addr, req_wdata, req_mask);
  end

  // Per-cycle comparison against the reference timeline
  always @(negedge clk) begin
    if (chk_en) begin
      exp_t e;
      bit bad;
      e = (exp_q.size() > 0) ? exp_q.pop_front() : idle_e();
      bad = (req_ready !== e.rdy) || (mem_ce1_n !== !e.ce) || (mem_ce2 !== e.ce) ||
            (mem_we_n !== !e.we) || (mem_oe_n !== !e.oe) || (mem_be_n !== e.be_n) ||
            (mem_dq_oe !== e.dq) || (e.ce && mem_addr !== e.addr) ||
            (e.dq && mem_dout !== e.dout) || (rsp_done !== e.done) ||
            (e.done && rsp_rdata !== e.rdata);
      vectors++;
      if (bad) begin
        miscompares++;
        $display("FAIL %s t=%0t actual rdy=%b ce1_n=%b ce2=%b we_n=%b oe_n=%b be_n=%b dq=%b addr=%h dout=%h done=%b rdata=%h expected rdy=%b ce=%b we=%b oe=%b be_n=%b dq=%b addr=%h dout=%h done=%b rdata=%h",
                 tag_name(e.tag), $time, req_ready, mem_ce1_n, mem_ce2, mem_we_n, mem_oe_n,
                 mem_be_n, mem_dq_oe, mem_addr, mem_dout, rsp_done, rsp_rdata,
                 e.rdy, e.ce, e.we, e.oe, e.be_n, e.dq, e.addr, e.dout, e.done, e.rdata);
      end
    end
  end

  // Behavioural memory with access time, release-gap and cycle-time checks
  int rd_age = 0;
  int oe_high = 100;
  int addr_gap = 100;
  bit prev_dq = 1'b0;
  logic [18:0] prev_addr = '0;
  bit pend = 1'b0;
  logic [18:0] pend_addr;
  logic [15:0] pend_data;
  logic [1:0]  pend_be_n;

  always @(negedge clk) begin
    if (!rst) begin
      bit sel, reading;
      logic [15:0] stored;
      sel = !mem_ce1_n && mem_ce2 && (mem_be_n != 2'b11);
      reading = sel && !mem_oe_n && mem_we_n;
      if (mem_dq_oe && reading) begin
        vectors++; miscompares++;
        $display("FAIL R7 contention: actual dq_oe=1 with oe_n=0, expected dq_oe=0");
      end
      if (!mem_oe_n) oe_high = 0; else if (oe_high < 100) oe_high++;
      if (mem_dq_oe && !prev_dq) begin
        vectors++;
        if ((oe_high - 1) * P_NS < T_HZ) begin
          miscompares++;
          $display("FAIL R7 release gap: actual %0d ns, expected >= %0d ns", (oe_high - 1) * P_NS, T_HZ);
        end
      end
      prev_dq = mem_dq_oe;
      if (mem_addr != prev_addr) begin
        vectors++;
        if (addr_gap * P_NS < T_RC) begin
          miscompares++;
          $display("FAIL R9 address cycle: actual %0d ns, expected >= %0d ns", addr_gap * P_NS, T_RC);
        end
        addr_gap = 1;
      end else if (addr_gap < 100) addr_gap++;
      prev_addr = mem_addr;
      if (sel && !mem_we_n) begin
        pend = 1'b1; pend_addr = mem_addr; pend_data = mem_dout; pend_be_n = mem_be_n;
      end else if (pend && mem_we_n) begin
        stored = sram_mem.exists(int'(pend_addr)) ? sram_mem[int'(pend_addr)] : 16'h0000;
        if (!pend_be_n[0]) stored[7:0] = pend_data[7:0];
        if (!pend_be_n[1]) stored[15:8] = pend_data[15:8];
        sram_mem[int'(pend_addr)] = stored;
        pend = 1'b0;
      end
      if (reading) rd_age++; else rd_age = 0;
      if (reading && rd_age * P_NS >= T_AA && rd_age * P_NS >= T_OE) begin
        stored = sram_mem.exists(int'(mem_addr)) ? sram_mem[int'(mem_addr)] : 16'h0000;
        mem_din = {mem_be_n[1] ? 8'hA5 : stored[15:8], mem_be_n[0] ? 8'hA5 : stored[7:0]};
      end else if (reading) begin
        mem_din = 16'hEEEE;
      end else begin
        mem_din = 16'h5A5A;
      end
    end
  end

  task automatic do_req(input bit w, input logic [18:0] a, input logic [15:0] d, input logic [1:0] m);
    bit acc;
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d; req_mask = m;
    acc = 1'b0;
    while (!acc) begin
      @(posedge clk);
      acc = req_ready;
    end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic gap(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL R2 watchdog: actual run still busy, expected completion");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: idle outputs while reset is held
    vectors++;
    if (!(req_ready === 1'b1 && mem_ce1_n === 1'b1 && mem_ce2 === 1'b0 && mem_we_n === 1'b1 &&
          mem_oe_n === 1'b1 && mem_be_n === 2'b11 && mem_dq_oe === 1'b0 && rsp_done === 1'b0)) begin
      miscompares++;
      $display("FAIL R1 reset: actual rdy=%b ce1_n=%b ce2=%b we_n=%b oe_n=%b be_n=%b dq=%b, expected 1 1 0 1 1 11 0",
               req_ready, mem_ce1_n, mem_ce2, mem_we_n, mem_oe_n, mem_be_n, mem_dq_oe);
    end
    rst = 1'b0;
    chk_en = 1'b1;
    gap(2);

    // R5 full-word write, R3/R4 read back
    do_req(1'b1, 19'd5, 16'h1234, 2'b11);
    do_req(1'b0, 19'd5, 16'h0000, 2'b11);
    // R7: write after read takes the release gap; R6 lower lane only
    do_req(1'b1, 19'd5, 16'hABCD, 2'b01);
    gap(3);
    do_req(1'b0, 19'd5, 16'h0000, 2'b11);
    do_req(1'b0, 19'd5, 16'h0000, 2'b10);
    do_req(1'b0, 19'd5, 16'h0000, 2'b01);
    // R6 upper lane only, then an empty mask leaves the word alone
    gap(10);
    do_req(1'b1, 19'd5, 16'h77EE, 2'b10);
    do_req(1'b1, 19'd5, 16'hFFFF, 2'b00);
    do_req(1'b0, 19'd5, 16'h0000, 2'b11);
    // R9 extreme addresses; back-to-back requests held valid (R2)
    do_req(1'b1, 19'h7FFFF, 16'hC3C3, 2'b11);
    do_req(1'b1, 19'h00000, 16'h0F0F, 2'b11);
    do_req(1'b0, 19'h7FFFF, 16'h0000, 2'b11);
    do_req(1'b0, 19'h00000, 16'h0000, 2'b11);
    do_req(1'b0, 19'h00000, 16'h0000, 2'b00);
    // Random mix
    for (int i = 0; i < 300; i++) begin
      logic [31:0] r;
      r = $urandom;
      do_req(r[0], {15'd0, r[4:1]}, r[31:16], r[6:5]);
      if (r[7]) gap(int'(r[9:8]));
    end
    gap(12);
    // R6: memory contents match the lane-masked write history
    foreach (mirror[k]) begin
      logic [15:0] got;
      got = sram_mem.exists(k) ? sram_mem[k] : 16'h0000;
      vectors++;
      if (got !== mirror[k]) begin
        miscompares++;
        $display("FAIL R6 memory word %0d: actual %h expected %h", k, got, mirror[k]);
      end
    end
    summary();
  end

endmodule